// File: doc/BRIEF.md
# Programmable Sixteen-Operation ALU

A purely combinational arithmetic-logic unit of parameterised width. Two operands and a 4-bit opcode select one of eight arithmetic operations, which share one adder, or one of eight logical operations, which bypass it. Alongside the result the block drives a 4-bit flag vector: signed overflow, adder carry-out, result-is-zero, and one reserved bit.

Operands wider than the datapath are handled by chaining. The words are presented least significant first. On the first word `first_word` is held high and the block supplies the carry-in the opcode needs. On every later word `first_word` is low and the previous word's carry flag is fed back on `carry_in`. One opcode performs a single step of a non-restoring signed division; the sequencing of the steps and the final correction are left to the surrounding logic. Each opcode and each of the three meaningful flags can be removed at elaboration time through mask parameters.

Top module: `multi_op_alu`

## Requirements
- R1: Arithmetic opcodes give: 0 = A+1, 1 = A-1, 2 = A+B, 3 = A-B, 4 = |A|, 5 = -A, 6 = division step, 7 = -B. All results are taken modulo 2^WIDTH.
- R2: Logical opcodes give: 8 = A AND B, 9 = A OR B, 10 = A XOR B, 11 = NOT B, 12 = A, 13 = NOT A, 14 = all zeros, 15 = the value one.
- R3: Flag bit 1 is the adder carry-out. Subtracting opcodes (1, 3, 5, 7, negative-operand 4, and 6 with equal sign bits) add the inverted operand, so a carry of 1 means no borrow.
- R4: Opcode 6 forms B-A when the sign bits of A and B are equal and B+A when they differ. It then shifts that sum left by one, so bit 0 of the result is 0.
- R5: With `first_word` high, `carry_in` has no effect and the carry-in is the opcode's natural value. That value is 1 for opcodes 0, 3, 5 and 7, for opcode 4 when A is negative, and for opcode 6 when the sign bits are equal; it is 0 otherwise. With `first_word` low, `carry_in` is used as the carry-in.
- R6: Flag bit 0 is set exactly when the signed sum formed by the adder falls outside the two's-complement range of WIDTH bits.
- R7: Flag bit 2 is set exactly when the result is zero, for every opcode. Flag bit 3 is always 0.
- R8: Flag bits 0 and 1 are 0 for every logical opcode (8 to 15).
- R9: An opcode whose bit in `OP_ENABLE` is 0 drives a zero result, and its flag bits 0 and 1 are 0.
- R10: A flag whose bit in `FLAG_ENABLE` is 0 (bit 0 = overflow, 1 = carry, 2 = zero) reads 0.
- R11: Chaining 8-bit words of add, subtract or negate-A, least significant first, yields the exact multi-word result and the final carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| opcode | input | 4 | Operation select |
| carry_in | input | 1 | Chained carry, used only while first_word is low |
| first_word | input | 1 | High on single-word operations and on the lowest word of a chain |
| result | output | WIDTH | Operation result |
| flags | output | 4 | {reserved, zero, carry, overflow} |

## Verification
In a chained word, the externally supplied carry and the opcode's own natural carry meet in the same evaluation, and only `first_word` decides which one wins. The bench provokes this by presenting identical operands with `carry_in` at both values. With `first_word` high the two results must match. In four-word chains the carry must come through and the 32-bit sum must be exact. A second overlap arises when the elaboration masks and the live opcode select coincide. A disabled opcode and a disabled flag are exercised on a masked instance, and its outputs are judged against zero while neighbouring opcodes still compute.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int NUM_OPS   = 16;
    localparam int NUM_FLAGS = 3;

    typedef enum logic [3:0] {
        OP_INC     = 4'd0,
        OP_DEC     = 4'd1,
        OP_ADD     = 4'd2,
        OP_SUB     = 4'd3,
        OP_ABS     = 4'd4,
        OP_NEGA    = 4'd5,
        OP_DIVSTEP = 4'd6,
        OP_NEGB    = 4'd7,
        OP_AND     = 4'd8,
        OP_OR      = 4'd9,
        OP_XOR     = 4'd10,
        OP_NOTB    = 4'd11,
        OP_PASSA   = 4'd12,
        OP_NOTA    = 4'd13,
        OP_CLEAR   = 4'd14,
        OP_ONE     = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic rsvd;
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

    function automatic logic is_logical(alu_op_e op);
        return op[3];
    endfunction

    // carry-in applied on a single word or on the lowest word of a chain
    function automatic logic natural_carry(alu_op_e op, logic a_neg, logic b_neg);
        case (op)
            OP_INC, OP_SUB, OP_NEGA, OP_NEGB: return 1'b1;
            OP_ABS:                           return a_neg;
            OP_DIVSTEP:                       return a_neg == b_neg;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    input  logic             first_word,
    input  logic             carry_in,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y,
    output logic             cin
);
    localparam int MSB = WIDTH - 1;

    logic nat_cin;

    always_comb begin
        x = '0;
        y = '0;
        case (op)
            OP_INC:     begin x = a;  y = '0; end
            OP_DEC:     begin x = a;  y = '1; end
            OP_ADD:     begin x = a;  y = b;  end
            OP_SUB:     begin x = a;  y = ~b; end
            OP_ABS:     begin x = a[MSB] ? '0 : a; y = a[MSB] ? ~a : '0; end
            OP_NEGA:    begin x = '0; y = ~a; end
            OP_DIVSTEP: begin x = b;  y = (a[MSB] == b[MSB]) ? ~a : a; end
            OP_NEGB:    begin x = '0; y = ~b; end
            default:    begin x = '0; y = '0; end
        endcase
        nat_cin = natural_carry(op, a[MSB], b[MSB]);
        cin     = first_word ? nat_cin : carry_in;
    end

    // R5: an add on the lowest word never picks up the external carry
    always_comb begin
        if (!$isunknown({op, first_word, carry_in})) begin
            a_r5_first_add_cin: assert (!(first_word && op == OP_ADD) || cin == 1'b0)
                else $error("first-word add took an external carry");
        end
    end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        {carry, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        ovf          = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] z
);
    always_comb begin
        case (op)
            OP_AND:   z = a & b;
            OP_OR:    z = a | b;
            OP_XOR:   z = a ^ b;
            OP_NOTB:  z = ~b;
            OP_PASSA: z = a;
            OP_NOTA:  z = ~a;
            OP_ONE:   z = WIDTH'(1);
            default:  z = '0;
        endcase
    end

endmodule

// File: rtl/multi_op_alu.sv
module multi_op_alu
    import alu_pkg::*;
#(
    parameter int                  WIDTH       = 8,
    parameter logic [NUM_OPS-1:0]   OP_ENABLE   = '1,
    parameter logic [NUM_FLAGS-1:0] FLAG_ENABLE = '1
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       opcode,
    input  logic             carry_in,
    input  logic             first_word,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] add_x, add_y, add_sum, arith_z, logic_z, pre_z;
    logic             add_cin, add_carry, add_ovf;
    logic             op_live;
    alu_flags_t       fl;

    assign op = alu_op_e'(opcode);

    alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .a          (opnd_a),
        .b          (opnd_b),
        .op         (op),
        .first_word (first_word),
        .carry_in   (carry_in),
        .x          (add_x),
        .y          (add_y),
        .cin        (add_cin)
    );

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .x     (add_x),
        .y     (add_y),
        .cin   (add_cin),
        .sum   (add_sum),
        .carry (add_carry),
        .ovf   (add_ovf)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (op),
        .z  (logic_z)
    );

    always_comb begin
        arith_z = (op == OP_DIVSTEP) ? {add_sum[MSB-1:0], 1'b0} : add_sum;
        pre_z   = is_logical(op) ? logic_z : arith_z;
        op_live = OP_ENABLE[opcode];
        result  = op_live ? pre_z : '0;

        fl.rsvd  = 1'b0;
        fl.ovf   = FLAG_ENABLE[0] && op_live && !is_logical(op) && add_ovf;
        fl.carry = FLAG_ENABLE[1] && op_live && !is_logical(op) && add_carry;
        fl.zero  = FLAG_ENABLE[2] && (result == '0);
        flags    = fl;
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, opcode, carry_in, first_word})) begin
            // R9: masked opcode yields zero
            a_r9_disabled_zero: assert (OP_ENABLE[opcode] || result == '0)
                else $error("disabled opcode drove a nonzero result");
            // R4: division step always leaves bit 0 clear
            a_r4_divstep_lsb: assert (opcode != 4'd6 || result[0] == 1'b0)
                else $error("division step result has bit 0 set");
            // R7: zero flag tracks the result
            a_r7_zero_flag: assert (!FLAG_ENABLE[2] || flags[2] == (result == '0))
                else $error("zero flag disagrees with result");
            // R8: no arithmetic flags for logical opcodes
            a_r8_logic_flags: assert (!opcode[3] || flags[1:0] == 2'b00)
                else $error("arithmetic flag set on logical opcode");
            // R10: masked carry flag stays low
            a_r10_carry_masked: assert (FLAG_ENABLE[1] || flags[1] == 1'b0)
                else $error("disabled carry flag asserted");
        end
    end

endmodule

// File: tb/multi_op_alu_test.sv
module multi_op_alu_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic [3:0]  op = 4'd14;
    logic        ci = 1'b0, first = 1'b1;
    logic [7:0]  r8, rd;
    logic [15:0] r16;
    logic [3:0]  f8, f16, fd;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multi_op_alu #(.WIDTH(8)) uut (
        .opnd_a(a16[7:0]), .opnd_b(b16[7:0]), .opcode(op),
        .carry_in(ci), .first_word(first), .result(r8), .flags(f8));

    multi_op_alu #(.WIDTH(16)) uut16 (
        .opnd_a(a16), .opnd_b(b16), .opcode(op),
        .carry_in(ci), .first_word(first), .result(r16), .flags(f16));

    // opcodes 2 and 9 removed, carry flag removed
    multi_op_alu #(.WIDTH(8), .OP_ENABLE(16'hFDFB), .FLAG_ENABLE(3'b101)) uutd (
        .opnd_a(a16[7:0]), .opnd_b(b16[7:0]), .opcode(op),
        .carry_in(ci), .first_word(first), .result(rd), .flags(fd));

    task automatic check(input string req, input longint got, input longint exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(input int o, input logic [15:0] a, input logic [15:0] b,
                         input logic f, input logic c);
        @(posedge clk);
        op = 4'(o); a16 = a; b16 = b; first = f; ci = c;
        @(negedge clk);
    endtask

    // reference: result and flags {rsvd, zero, carry, ovf}
    function automatic void model(input int w, input int o, input longint a, input longint b,
                                  input bit f, input bit c_ext,
                                  output longint z, output logic [3:0] fl);
        longint m  = (64'sd1 <<< w) - 1;
        longint h  = 64'sd1 <<< (w - 1);
        longint sa = (a >= h) ? a - (m + 1) : a;
        longint sb = (b >= h) ? b - (m + 1) : b;
        longint t = 0, s = 0;
        longint c;
        bit carry = 0, ovf = 0;
        case (o)
            0: begin c = f ? 1 : c_ext; t = a + c;           s = sa + c; end
            1: begin c = f ? 0 : c_ext; t = a + m + c;       s = sa - 1 + c; end
            2: begin c = f ? 0 : c_ext; t = a + b + c;       s = sa + sb + c; end
            3: begin c = f ? 1 : c_ext; t = a + (m ^ b) + c; s = sa - sb - 1 + c; end
            4: if (sa < 0) begin c = f ? 1 : c_ext; t = (m ^ a) + c; s = -sa - 1 + c; end
               else        begin c = f ? 0 : c_ext; t = a + c;       s = sa + c; end
            5: begin c = f ? 1 : c_ext; t = (m ^ a) + c;     s = -sa - 1 + c; end
            6: if ((sa < 0) == (sb < 0)) begin c = f ? 1 : c_ext; t = b + (m ^ a) + c; s = sb - sa - 1 + c; end
               else                      begin c = f ? 0 : c_ext; t = b + a + c;       s = sb + sa + c; end
            7: begin c = f ? 1 : c_ext; t = (m ^ b) + c;     s = -sb - 1 + c; end
            default: ;
        endcase
        if (o < 8) begin
            z     = (o == 6) ? ((t <<< 1) & m) : (t & m);
            carry = ((t >>> w) & 1) != 0;
            ovf   = (s > h - 1) || (s < -h);
        end else begin
            case (o)
                8:  z = a & b;
                9:  z = a | b;
                10: z = a ^ b;
                11: z = m ^ b;
                12: z = a;
                13: z = m ^ a;
                14: z = 0;
                default: z = 1;
            endcase
        end
        fl = {1'b0, z == 0, carry, ovf};
    endfunction

    task automatic t_all_zero_inputs;
        drive(14, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R7 clear result", r8, 0);
        check("R7 zero flag set, rsvd clear", f8, 4'b0100);
        drive(15, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R2 one opcode", r16, 1);
        check("R7 zero flag clear on one", f16, 4'b0000);
    endtask

    task automatic t_sweep;
        longint z; logic [3:0] fl;
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 40; i++) begin
                logic [15:0] a = 16'($urandom);
                logic [15:0] b = 16'($urandom);
                if (i == 0) begin a = '0; b = '0; end
                if (i == 1) begin a = 16'h8080; b = 16'h7F7F; end
                drive(o, a, b, 1'b1, i[0]);
                model(8, o, longint'(a[7:0]), longint'(b[7:0]), 1'b1, 1'b0, z, fl);
                check(o < 8 ? "R1 result w8" : "R2 result w8", r8, z);
                check(o < 8 ? "R3 R6 flags w8" : "R8 flags w8", f8, fl);
                model(16, o, longint'(a), longint'(b), 1'b1, 1'b0, z, fl);
                check(o < 8 ? "R1 result w16" : "R2 result w16", r16, z);
                check(o < 8 ? "R3 R6 flags w16" : "R8 flags w16", f16, fl);
            end
        end
    endtask

    task automatic t_overflow_corners;
        drive(0, 16'h007F, 16'h0, 1'b1, 1'b0);
        check("R6 inc 7F result", r8, 8'h80);
        check("R6 inc 7F flags", f8, 4'b0001);
        drive(1, 16'h0080, 16'h0, 1'b1, 1'b0);
        check("R6 dec 80 flags", f8, 4'b0011);
        drive(5, 16'h0080, 16'h0, 1'b1, 1'b0);
        check("R6 neg 80 result", r8, 8'h80);
        check("R6 neg 80 flags", f8, 4'b0001);
        drive(4, 16'h0080, 16'h0, 1'b1, 1'b0);
        check("R6 abs 80 flags", f8, 4'b0001);
        drive(3, 16'h0003, 16'h0005, 1'b1, 1'b0);
        check("R3 borrow clears carry", f8, 4'b0000);
        drive(3, 16'h0005, 16'h0005, 1'b1, 1'b0);
        check("R3 no borrow sets carry", f8, 4'b0110);
    endtask

    task automatic t_divstep;
        // equal signs: (20 - 6) << 1 = 28
        drive(6, 16'h0006, 16'h0014, 1'b1, 1'b0);
        check("R4 same sign", r8, 8'd28);
        // differing signs: (-3 + 6) << 1 = 6
        drive(6, 16'h0006, 16'h00FD, 1'b1, 1'b0);
        check("R4 differing sign", r8, 8'd6);
        // bit shifted out: (0x50 + 0x90) << 1 = 0xC0 within 8 bits
        drive(6, 16'h0050, 16'h0090, 1'b1, 1'b0);
        check("R4 top bit dropped", r8, 8'hC0);
    endtask

    task automatic t_first_word_gate;
        logic [7:0] keep;
        for (int o = 0; o < 8; o++) begin
            drive(o, 16'h1234, 16'h00A5, 1'b1, 1'b0);
            keep = r8;
            drive(o, 16'h1234, 16'h00A5, 1'b1, 1'b1);
            check("R5 carry_in ignored on first word", r8, keep);
        end
        drive(2, 16'h0010, 16'h0001, 1'b0, 1'b1);
        check("R5 carry_in used on later word", r8, 8'h12);
        drive(3, 16'h0010, 16'h0001, 1'b0, 1'b0);
        check("R5 borrow applied on later word", r8, 8'h0E);
    endtask

    task automatic t_chain;
        for (int k = 0; k < 6; k++) begin
            int          o = (k % 3 == 0) ? 2 : (k % 3 == 1) ? 3 : 5;
            logic [31:0] x = $urandom;
            logic [31:0] y = $urandom;
            logic [31:0] got = '0;
            logic        cy = 1'b0;
            logic [32:0] exp;
            for (int wd = 0; wd < 4; wd++) begin
                drive(o, {8'h0, x[8*wd +: 8]}, {8'h0, y[8*wd +: 8]}, wd == 0, cy);
                got[8*wd +: 8] = r8;
                cy = f8[1];
            end
            if (o == 2)      exp = {1'b0, x} + {1'b0, y};
            else if (o == 3) exp = {1'b0, x} + {1'b0, ~y} + 33'd1;
            else             exp = {1'b0, ~x} + 33'd1;
            check("R11 chained result", got, exp[31:0]);
            check("R11 chained carry", cy, exp[32]);
        end
    endtask

    task automatic t_masked;
        drive(2, 16'h0005, 16'h0007, 1'b1, 1'b0);
        check("R9 disabled add result", rd, 0);
        check("R9 disabled add flags", fd, 4'b0100);
        check("R9 neighbour instance still adds", r8, 8'd12);
        drive(9, 16'h0005, 16'h0003, 1'b1, 1'b0);
        check("R9 disabled or result", rd, 0);
        drive(3, 16'h0005, 16'h0003, 1'b1, 1'b0);
        check("R10 enabled sub result", rd, 8'd2);
        check("R10 carry flag masked", fd, 4'b0000);
        drive(0, 16'h00FF, 16'h0, 1'b1, 1'b0);
        check("R10 masked carry on wrap", fd, 4'b0100);
        drive(0, 16'h007F, 16'h0, 1'b1, 1'b0);
        check("R10 overflow still live", fd, 4'b0001);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_all_zero_inputs();
        t_sweep();
        t_overflow_corners();
        t_divstep();
        t_first_word_gate();
        t_chain();
        t_masked();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule